// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits, split into a lower and an upper byte lane. The host issues one request at a time. Each request is a read or a write with an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns it into a sequence of active-low strobes on the memory pins: chip select, output enable, write enable and one enable per byte lane. Every strobe comes straight from a register.

The length of each phase is a whole number of clock cycles. It is the ceiling of a nanosecond minimum divided by the clock period, and never less than one cycle. The nanosecond minimums are parameters, and their defaults are the 70 ns speed grade. Writes are controlled by write enable. Address and lane enables are set up one cycle before write enable falls. The controller drives the data bus only after the memory's write-to-high-Z interval has passed, and it releases the bus on the same edge that write enable rises. For a read, output enable is held low for the longest of the access times. The data is captured at the end of that phase, lanes that were not selected are returned as zero, and a one-cycle valid pulse goes to the host.

Top module: `sram_ctl`

## Requirements
- R1: While reset is active and after it, until a request is accepted, chip select, output enable, write enable and both lane enables are high, the data drive enable is low, rvalid is low and ready is high.
- R2: A request is accepted on a clock edge where req and ready are both high. Ready then stays low until the cycle is complete, and any request presented while ready is low is ignored.
- R3: In a write, chip select, the lane enables and the address become valid one cycle before write enable falls. Address and lane enables do not change while chip select is low.
- R4: Write enable stays low for max(ceil(tWP/T), ceil(tAW/T), ceil(tWHZ/T)+ceil(tDW/T)) cycles, which is 6 at the defaults. A write keeps ready low for 1 + that count + max(1, ceil(tWC/T) − 1 − that count) cycles, which is 8 at the defaults.
- R5: The data drive enable is high only while chip select and write enable are both low. It rises after ceil(tWHZ/T) cycles of write enable low (3 at the defaults) and falls on the edge where write enable rises.
- R6: Mask bit 0 selects the lower lane (data bits 7:0, lower enable) and mask bit 1 selects the upper lane (bits 15:8, upper enable). A write changes only the selected lanes.
- R7: A read holds chip select and output enable low and write enable high for max(ceil(tRC/T), ceil(tAA/T), ceil(tOE/T), ceil(tBA/T)) cycles, which is 7 at the defaults. Output enable and write enable are never low together.
- R8: Read data is captured on the last cycle of the read phase. rvalid is high for exactly one cycle, in the first cycle after the strobes are released, and lanes that were not selected read as zero.
- R9: A request with mask 00 still runs its full cycle with both lane enables high. A write leaves memory unchanged, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| ready_o | output | 1 | Controller idle and able to accept a request |
| rdata_o | output | 16 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o valid |
| mem_addr_o | output | 18 | Memory address |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_lb_n_o | output | 1 | Lower byte enable, active low |
| mem_ub_n_o | output | 1 | Upper byte enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Data drive enable for the bus pads |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The bench builds the block with its default parameters: a 10 ns clock and the 70 ns grade timings. At these values the write pulse is 6 cycles, the drive delay 3 cycles, the write cycle 8 cycles and the read phase 7 cycles, and the bench computes each of these counts from the ceiling formulas. This configuration lets the bench sweep every combination of write mask and read mask over sixteen addresses. A small behavioural memory samples the strobes, and a request presented while the controller is busy checks that it is ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WREC = 3'd3,
    ST_RACC = 3'd4
  } seq_state_e;

  // Clock cycles covering a nanosecond minimum; never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int per_ns);
    int c;
    c = (ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int N_WP   = 6,
  parameter int N_WREC = 1,
  parameter int N_RD   = 7,
  parameter int N_WHZ  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic ready,
  output logic load_en,
  output logic cap_en,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam int MAXC  = imax(imax(N_WP, N_WREC), N_RD);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] WREC_LD = CNT_W'(N_WREC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] DRV_LIM = CNT_W'(N_WP - 1 - N_WHZ);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             cs_n_d, oe_n_d, we_n_d, dq_oe_d;

  assign last    = (cnt_q == '0);
  assign ready   = (state_q == ST_IDLE);
  assign load_en = ready && req;
  assign cap_en  = (state_q == ST_RACC) && last;

  // Next-state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (req) begin
        state_d = wr ? ST_WSET : ST_RACC;
        cnt_d   = wr ? '0 : RD_LD;
      end
      ST_WSET: if (last) begin
        state_d = ST_WPUL;
        cnt_d   = WP_LD;
      end
      ST_WPUL: if (last) begin
        state_d = ST_WREC;
        cnt_d   = WREC_LD;
      end
      ST_WREC: if (last) state_d = ST_IDLE;
      ST_RACC: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes decoded from the next state so that the pins come from flops
  always_comb begin
    cs_n_d  = (state_d == ST_IDLE);
    oe_n_d  = (state_d != ST_RACC);
    we_n_d  = (state_d != ST_WPUL);
    dq_oe_d = (state_d == ST_WPUL) && (cnt_d <= DRV_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_n    <= cs_n_d;
      oe_n    <= oe_n_d;
      we_n    <= we_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  a_r5_drive_inside_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !cs_n));
  a_r5_release_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !dq_oe);
  a_r3_we_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!cs_n));
  a_r7_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n));
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !ready);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic                   cap_en,
  input  logic                   cs_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W/8-1:0]    mask_i,
  input  logic [DATA_W-1:0]      dq_i,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      dq_o,
  output logic [DATA_W/8-1:0]    be_n,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rvalid
);

  localparam int NLANE = DATA_W / 8;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [NLANE-1:0]  mask_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (load_en) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      mask_q  <= mask_i;
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign be_n[l] = cs_n | ~mask_q[l];
    assign rdata_d[8*l +: 8] = mask_q[l] ? dq_i[8*l +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_en;
      if (cap_en) rdata_q <= rdata_d;
    end
  end

  assign mem_addr = addr_q;
  assign dq_o     = wdata_q;
  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(mem_addr) && $stable(be_n)));
  a_r8_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  a_r8_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !mask_q[0]) |-> (rdata[7:0] == 8'h00));
  a_r1_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (be_n == '1));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_AW_NS = 60,
  parameter int T_BW_NS = 60,
  parameter int T_DW_NS = 30,
  parameter int T_WHZ_NS = 25,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_BA_NS = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        mask_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_lb_n_o,
  output logic              mem_ub_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_WHZ = ns_to_cyc(T_WHZ_NS, CLK_NS);
  localparam int N_WP  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                              imax(ns_to_cyc(T_BW_NS, CLK_NS), N_WHZ + ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int N_WREC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - 1 - N_WP);
  localparam int N_RD  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                              imax(ns_to_cyc(T_OE_NS, CLK_NS), ns_to_cyc(T_BA_NS, CLK_NS)));

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_en, cap_en, cs_n, oe_n, we_n;
  logic [1:0] be_n;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sram_ctl_seq #(
    .N_WP(N_WP), .N_WREC(N_WREC), .N_RD(N_RD), .N_WHZ(N_WHZ)
  ) seq_i (
    .clk(clk), .rst_n(rst_int_n), .req(req_i), .wr(wr_i),
    .ready(ready_o), .load_en(load_en), .cap_en(cap_en),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .dq_oe(mem_dq_oe_o)
  );

  sram_ctl_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) lanes_i (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .cap_en(cap_en),
    .cs_n(cs_n), .addr_i(addr_i), .wdata_i(wdata_i), .mask_i(mask_i),
    .dq_i(mem_dq_i), .mem_addr(mem_addr_o), .dq_o(mem_dq_o), .be_n(be_n),
    .rdata(rdata_o), .rvalid(rvalid_o)
  );

  assign mem_cs_n_o = cs_n;
  assign mem_oe_n_o = oe_n;
  assign mem_we_n_o = we_n;
  assign mem_lb_n_o = be_n[0];
  assign mem_ub_n_o = be_n[1];

  a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!mem_oe_n_o && !mem_we_n_o));
  a_r9_no_lane_no_strobe_effect: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_cs_n_o |-> (mem_lb_n_o && mem_ub_n_o && !mem_dq_oe_o));

endmodule

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  localparam int T = 10;
  function automatic int cd(input int ns);
    int c;
    c = (ns + T - 1) / T;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int EXP_WHZ  = cd(25);
  localparam int EXP_WP   = mx(mx(cd(55), cd(60)), EXP_WHZ + cd(30));
  localparam int EXP_WBSY = 1 + EXP_WP + mx(1, cd(70) - 1 - EXP_WP);
  localparam int EXP_RD   = mx(mx(cd(70), cd(70)), mx(cd(35), cd(35)));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready, rvalid, cs_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [17:0] maddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] dev [64];
  logic [15:0] expm [64];
  logic [15:0] pend;
  logic        prev_we = 1'b1;

  always #(T/2) clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .mem_addr_o(maddr), .mem_cs_n_o(cs_n),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_lb_n_o(lb_n),
    .mem_ub_n_o(ub_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // Behavioural memory: drives its word during reads, garbage elsewhere
  assign dq_i = (!cs_n && !oe_n && we_n) ?
                {ub_n ? 8'hEE : dev[maddr[5:0]][15:8], lb_n ? 8'hEE : dev[maddr[5:0]][7:0]}
                : 16'hDEAD;

  always @(negedge clk) begin
    if (!cs_n && !we_n && dq_oe) pend <= dq_o;
    if (we_n && !prev_we) begin
      if (!lb_n) dev[maddr[5:0]][7:0]  <= pend[7:0];
      if (!ub_n) dev[maddr[5:0]][15:8] <= pend[15:8];
    end
    prev_we <= we_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m,
                          input bit poke);
    int busy = 0, wel = 0, drv = 0, wel_before = -1, csl = 0;
    bit addr_ok = 1, first_ok;
    @(negedge clk);
    req = 1; wr = 1; addr = a; wdata = d; mask = m;
    @(negedge clk);
    first_ok = !cs_n && we_n && (maddr == a);
    check(first_ok, "R3 setup cycle before WE", {cs_n, we_n}, 2'b01);
    if (poke) begin addr = a ^ 18'h00011; wdata = ~d; mask = 2'b11; wr = 1; end
    else req = 0;
    forever begin
      if (ready) begin req = 0; break; end
      busy++;
      if (!cs_n) begin csl++; if (maddr != a) addr_ok = 0; end
      if (!we_n) begin
        if (dq_oe && wel_before < 0) wel_before = wel;
        wel++;
      end
      if (dq_oe) drv++;
      @(negedge clk);
    end
    check(busy == EXP_WBSY, "R4 write busy cycles", busy, EXP_WBSY);
    check(wel == EXP_WP, "R4 WE low cycles", wel, EXP_WP);
    check(csl >= cd(70), "R4 write cycle length", csl, cd(70));
    check(addr_ok, "R3 address stable", 0, 1);
    check(wel_before == EXP_WHZ, "R5 drive delay", wel_before, EXP_WHZ);
    check(drv == EXP_WP - EXP_WHZ, "R5 drive cycles", drv, EXP_WP - EXP_WHZ);
    if (m[0]) expm[a[5:0]][7:0]  = d[7:0];
    if (m[1]) expm[a[5:0]][15:8] = d[15:8];
    @(negedge clk);
    check(dev[a[5:0]] == expm[a[5:0]], m == 0 ? "R9 empty-mask write" : "R6 lane write",
          dev[a[5:0]], expm[a[5:0]]);
    if (poke) check(dev[(a[5:0]) ^ 6'h11] == expm[(a[5:0]) ^ 6'h11], "R2 busy request ignored",
                    dev[(a[5:0]) ^ 6'h11], expm[(a[5:0]) ^ 6'h11]);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m);
    int busy = 0, oel = 0, rv = 0;
    logic [15:0] got = '0, exp;
    bit bad = 0;
    @(negedge clk);
    req = 1; wr = 0; addr = a; mask = m;
    @(negedge clk);
    req = 0;
    forever begin
      if (rvalid) begin rv++; got = rdata; end
      if (ready) break;
      busy++;
      if (!oe_n) oel++;
      if (!oe_n && (!we_n || cs_n)) bad = 1;
      @(negedge clk);
    end
    @(negedge clk);
    if (rvalid) rv++;
    exp = {m[1] ? expm[a[5:0]][15:8] : 8'h00, m[0] ? expm[a[5:0]][7:0] : 8'h00};
    check(oel == EXP_RD && busy == EXP_RD, "R7 read phase cycles", oel, EXP_RD);
    check(!bad, "R7 read strobes", 1, 0);
    check(rv == 1, "R8 rvalid single pulse", rv, 1);
    check(got == exp, m == 0 ? "R9 empty-mask read" : "R8 read data", got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dev[i] = 16'(i * 16'h0101 + 16'h3C5A);
      expm[i] = dev[i];
    end
    repeat (3) @(negedge clk);
    check(cs_n && oe_n && we_n && lb_n && ub_n && !dq_oe && !rvalid && ready,
          "R1 reset state", {cs_n, oe_n, we_n, lb_n, ub_n, dq_oe, rvalid, ready}, 8'hF9);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(cs_n && oe_n && we_n && lb_n && ub_n && !dq_oe && !rvalid && ready,
          "R1 idle after reset", {cs_n, oe_n, we_n, lb_n, ub_n, dq_oe, rvalid, ready}, 8'hF9);
    for (int i = 0; i < 16; i++) begin
      for (int wm = 0; wm < 4; wm++) begin
        logic [17:0] a;
        a = {12'(i * 263 + wm * 1021), 6'(i * 3)};
        do_write(a, 16'(16'hA000 + i * 16'h1111 + wm * 16'h0707), 2'(wm), (i == 5 && wm == 3));
        for (int rm = 0; rm < 4; rm++) do_read(a, 2'(rm));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule